// File: doc/BRIEF.md
# Windowed Deadman Timer with Two-Step Service Keys

This block is a memory-mapped deadman timer. Once software sets its enable bit, it counts system clocks. Software must service it before the count reaches a fixed limit, and it may do so only inside a service window that opens near the end of that count. Servicing takes two writes. First an arming key goes to one address, then a release key goes to another. Only a correct pair, with the second key landing while the window is open, sends the count back to zero.

Any mistake raises a sticky status event and a one-cycle reset request. A mistake is a wrong arming value, a wrong release value, a release with no arming write before it, or a release outside the window. The same two outputs fire if the count runs out. A run-out also sets a sticky reset-cause flag. That flag stands in for a reset controller's record of why the chip was reset, and software clears it through a separate clear address.

The limit and the window length are elaboration parameters, and the bus can read both back. Software converts the limit to seconds by dividing by its clock rate. Register access is a plain single-cycle strobe: a read returns its data on `bus_rdata` one clock after the strobe, and a write takes effect at that same edge.

Top module: `svc_window_wdt`

## Requirements
- R1: After reset, the timer is disabled. The counter reads 0, the status register reads 0 and the reset-cause register reads 0.
- R2: Bit 15 of the control register (offset 0x00) is the enable. While it is 1, the counter (offset 0x40) rises by one per clock. While it is 0, the counter is held at 0.
- R3: Status bit 0 (offset 0x30) is 1 exactly when the timer is enabled and the counter is at least TIMEOUT_CNT-WIN_INTV and below TIMEOUT_CNT. Offsets 0x60 and 0x70 read back TIMEOUT_CNT and WIN_INTV.
- R4: A valid service resets the counter to 0, sets no flag and raises no reset request. A valid service is a write of 0x4000 to offset 0x10, followed by a write of 0x08 to offset 0x20 while the window is open.
- R5: Any value other than 0x4000 written to offset 0x10 while enabled sets status bit 7 and status bit 5. It also raises `rst_req` for one clock.
- R6: A write to offset 0x20 while enabled that is not part of a valid service sets status bit 6 and status bit 5, and raises `rst_req` for one clock. This covers a wrong value, a write with no arming write before it, and a write while the window is closed.
- R7: When the enabled counter reaches TIMEOUT_CNT, the block sets status bit 5 and pulses `rst_req` for exactly one clock. It also sets bit 5 of the reset-cause register (offset 0x80), and the counter restarts from 0.
- R8: Writing a 1 in bit 5 to offset 0x84 clears the reset-cause flag. A write to 0x84 with bit 5 at 0 leaves the flag unchanged.
- R9: In the clock that follows a write clearing the enable bit, every bus access is ignored. Such a write has no effect, and such a read returns 0.
- R10: Status bits 5, 6 and 7 clear only on reset. Key writes to 0x10 or 0x20 while the timer is disabled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after a read strobe |
| win_open | output | 1 | Service window open |
| rst_req | output | 1 | One-clock reset request |
| rst_cause | output | 1 | Sticky timeout reset-cause flag |

## Verification
The service path is exercised with several patterns:
- a correct key pair inside the window,
- a correct pair whose release lands before the window opens,
- a release with no arming write,
- a wrong release value,
- a wrong arming value.

Together these separate the window check from the key-value checks and from the arming order. Reads across the window edges place its opening one count early or late. A full unattended run-out, followed by cause-flag clears with bit 5 set and with bit 5 clear, separates a timeout from a key error. A disable followed at once by a re-enable write shows whether the one-clock lockout exists. Every clock, `rst_req` is compared against a model built from the requirements, so pulse width and pulse timing are both covered.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int AW = 8;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_CTRL      = 8'h00;
  localparam logic [AW-1:0] A_ARM       = 8'h10;
  localparam logic [AW-1:0] A_RELEASE   = 8'h20;
  localparam logic [AW-1:0] A_STAT      = 8'h30;
  localparam logic [AW-1:0] A_COUNT     = 8'h40;
  localparam logic [AW-1:0] A_LIMIT     = 8'h60;
  localparam logic [AW-1:0] A_WINDOW    = 8'h70;
  localparam logic [AW-1:0] A_CAUSE     = 8'h80;
  localparam logic [AW-1:0] A_CAUSE_CLR = 8'h84;

  localparam logic [DW-1:0] KEY_ARM     = 32'h0000_4000;
  localparam logic [DW-1:0] KEY_RELEASE = 32'h0000_0008;

  localparam int EN_BIT    = 15;
  localparam int CAUSE_BIT = 5;

  // status image, msb to lsb: bad arm, bad release, event, 4 spare, window
  typedef struct packed {
    logic       bad_arm;
    logic       bad_rel;
    logic       evt;
    logic [3:0] spare;
    logic       win;
  } stat_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned TIMEOUT_CNT = 1000,
  parameter int unsigned WIN_INTV    = 200,
  parameter int unsigned CW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on,
  input  logic          service,
  output logic [CW-1:0] cnt,
  output logic          win_open,
  output logic          expire
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CNT);
  localparam logic [CW-1:0] OPENS = CW'(TIMEOUT_CNT - WIN_INTV);

  assign expire   = on && (cnt == LIMIT);
  assign win_open = on && (cnt >= OPENS) && (cnt < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (!on || service || expire) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_keys.sv
module wdt_keys
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on,
  input  logic          arm_wr,
  input  logic          rel_wr,
  input  logic [DW-1:0] wdata,
  input  logic          win_open,
  input  logic          expire,
  output logic          service,
  output logic          evt,
  output logic          bad_arm,
  output logic          bad_rel,
  output logic          rst_req
);
  logic armed;
  logic good_arm, arm_err, rel_err;

  assign good_arm = arm_wr && (wdata == KEY_ARM);
  assign arm_err  = arm_wr && !good_arm;
  assign service  = rel_wr && armed && (wdata == KEY_RELEASE) && win_open;
  assign rel_err  = rel_wr && !service;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      evt     <= 1'b0;
      bad_arm <= 1'b0;
      bad_rel <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (!on || arm_err || rel_wr) armed <= 1'b0;
      else if (good_arm)            armed <= 1'b1;
      bad_arm <= bad_arm | arm_err;
      bad_rel <= bad_rel | rel_err;
      evt     <= evt | arm_err | rel_err | expire;
      rst_req <= arm_err | rel_err | expire;
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CNT = 1000,
  parameter int unsigned WIN_INTV    = 200,
  parameter int unsigned CW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [CW-1:0] cnt,
  input  logic          win_open,
  input  logic          evt,
  input  logic          bad_arm,
  input  logic          bad_rel,
  input  logic          expire,
  output logic          on,
  output logic          arm_wr,
  output logic          rel_wr,
  output logic          cause
);
  logic          lock;
  logic          acc, wr;
  stat_t         stat;
  logic [DW-1:0] rmux;

  assign acc    = bus_en && !lock;
  assign wr     = acc && bus_we;
  assign arm_wr = wr && on && (bus_addr == A_ARM);
  assign rel_wr = wr && on && (bus_addr == A_RELEASE);

  always_comb begin
    stat         = '0;
    stat.win     = win_open;
    stat.evt     = evt;
    stat.bad_rel = bad_rel;
    stat.bad_arm = bad_arm;
  end

  always_comb begin
    rmux = '0;
    case (bus_addr)
      A_CTRL:   rmux[EN_BIT] = on;
      A_STAT:   rmux = DW'(stat);
      A_COUNT:  rmux = DW'(cnt);
      A_LIMIT:  rmux = DW'(TIMEOUT_CNT);
      A_WINDOW: rmux = DW'(WIN_INTV);
      A_CAUSE:  rmux[CAUSE_BIT] = cause;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on        <= 1'b0;
      lock      <= 1'b0;
      cause     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr && bus_addr == A_CTRL) on <= bus_wdata[EN_BIT];
      lock <= wr && (bus_addr == A_CTRL) && on && !bus_wdata[EN_BIT];
      if (expire) cause <= 1'b1;
      else if (wr && bus_addr == A_CAUSE_CLR && bus_wdata[CAUSE_BIT]) cause <= 1'b0;
      if (bus_en && !bus_we) bus_rdata <= lock ? '0 : rmux;
    end
  end
endmodule

// File: rtl/svc_window_wdt.sv
module svc_window_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CNT = 1000,
  parameter int unsigned WIN_INTV    = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          win_open,
  output logic          rst_req,
  output logic          rst_cause
);
  localparam int unsigned CW = $clog2(TIMEOUT_CNT + 1);

  logic [CW-1:0] cnt;
  logic on, arm_wr, rel_wr, service, expire, evt, bad_arm, bad_rel;

  wdt_regs #(.TIMEOUT_CNT(TIMEOUT_CNT), .WIN_INTV(WIN_INTV), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .win_open(win_open), .evt(evt), .bad_arm(bad_arm),
    .bad_rel(bad_rel), .expire(expire), .on(on), .arm_wr(arm_wr),
    .rel_wr(rel_wr), .cause(rst_cause)
  );

  wdt_counter #(.TIMEOUT_CNT(TIMEOUT_CNT), .WIN_INTV(WIN_INTV), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .on(on), .service(service),
    .cnt(cnt), .win_open(win_open), .expire(expire)
  );

  wdt_keys u_keys (
    .clk(clk), .rst_n(rst_n), .on(on), .arm_wr(arm_wr), .rel_wr(rel_wr),
    .wdata(bus_wdata), .win_open(win_open), .expire(expire),
    .service(service), .evt(evt), .bad_arm(bad_arm), .bad_rel(bad_rel),
    .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_sva.sv
module wdt_sva #(
  parameter int unsigned T  = 1000,
  parameter int unsigned CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          on,
  input logic [CW-1:0] cnt,
  input logic          win_open,
  input logic          expire,
  input logic          rst_req,
  input logic          evt,
  input logic          bad_arm,
  input logic          bad_rel,
  input logic          cause
);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(T));
  assert_off_holds_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (cnt == '0));
  assert_window_needs_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> on);
  assert_expire_requests_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rst_req && evt && cause));
  assert_req_has_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> evt);
  assert_evt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> evt);
  assert_bad_arm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_arm |=> bad_arm);
  assert_bad_rel_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rel |=> bad_rel);
endmodule

bind svc_window_wdt wdt_sva #(.T(TIMEOUT_CNT), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .on(on), .cnt(cnt), .win_open(win_open),
  .expire(expire), .rst_req(rst_req), .evt(evt), .bad_arm(bad_arm),
  .bad_rel(bad_rel), .cause(rst_cause)
);

// File: tb/tb_svc_window_wdt.sv
`timescale 1ns/1ps
module tb_svc_window_wdt;
  localparam int T = 40;
  localparam int W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        win_open, rst_req, rst_cause;

  svc_window_wdt #(.TIMEOUT_CNT(T), .WIN_INTV(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .win_open(win_open), .rst_req(rst_req), .rst_cause(rst_cause)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // scoreboard queues, one entry per driven clock edge
  bit          q_isrd[$];
  logic [31:0] q_rd[$];
  bit          q_rst[$];
  int          q_req[$];

  // reference state kept from the requirements
  bit m_on, m_lock, m_arm, m_evt, m_b1, m_b2, m_cause;
  int m_cnt;

  task automatic model_reset();
    m_on = 0; m_lock = 0; m_arm = 0; m_evt = 0; m_b1 = 0; m_b2 = 0;
    m_cause = 0; m_cnt = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a, input bit win);
    case (a)
      8'h00: return {16'h0, m_on, 15'h0};
      8'h30: return {24'h0, m_b1, m_b2, m_evt, 4'h0, win};
      8'h40: return 32'(m_cnt);
      8'h60: return 32'(T);
      8'h70: return 32'(W);
      8'h80: return {26'h0, m_cause, 5'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input bit en, input bit we, input logic [7:0] a,
                      input logic [31:0] d, input int req);
    bit win, expire, acc, wr, arm_w, rel_w, good_arm, svc, bad1, bad2;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    win    = m_on && m_cnt >= T - W && m_cnt < T;
    expire = m_on && m_cnt == T;
    acc    = en && !m_lock;
    wr     = acc && we;
    arm_w  = wr && m_on && a == 8'h10;
    rel_w  = wr && m_on && a == 8'h20;
    good_arm = arm_w && d == 32'h4000;
    svc    = rel_w && m_arm && d == 32'h8 && win;
    bad1   = arm_w && !good_arm;
    bad2   = rel_w && !svc;
    q_isrd.push_back(en && !we);
    q_rd.push_back(m_lock ? 32'h0 : model_read(a, win));
    q_rst.push_back(bad1 || bad2 || expire);
    q_req.push_back(req);
    m_evt = m_evt | bad1 | bad2 | expire;
    m_b1  = m_b1 | bad1;
    m_b2  = m_b2 | bad2;
    if (expire) m_cause = 1;
    else if (wr && a == 8'h84 && d[5]) m_cause = 0;
    if (!m_on || bad1 || rel_w) m_arm = 0;
    else if (good_arm) m_arm = 1;
    if (!m_on || svc || expire) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    m_lock = wr && a == 8'h00 && m_on && !d[15];
    if (wr && a == 8'h00) m_on = d[15];
  endtask

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 32'h0, req);
  endtask

  task automatic rd(input logic [7:0] a, input int req);
    step(1, 0, a, 32'h0, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input int req);
    step(1, 1, a, d, req);
  endtask

  // monitor: compares each edge's result against the scoreboard
  always @(posedge clk) begin : mon
    bit isrd, erst;
    logic [31:0] erd;
    int req;
    #1;
    if (q_isrd.size() > 0) begin
      isrd = q_isrd.pop_front(); erd = q_rd.pop_front();
      erst = q_rst.pop_front();  req = q_req.pop_front();
      n_tests++;
      if (rst_req !== erst) begin
        n_fail++;
        $display("FAIL R%0d rst_req actual=%0b expected=%0b", req, rst_req, erst);
      end
      if (isrd) begin
        n_tests++;
        if (bus_rdata !== erd) begin
          n_fail++;
          $display("FAIL R%0d rdata actual=%h expected=%h", req, bus_rdata, erd);
        end
      end
    end
  end

  task automatic apply_reset();
    @(negedge clk);
    bus_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1;
  endtask

  initial begin
    model_reset();
    apply_reset();
    // R1 reset state
    rd(8'h00, 1); rd(8'h30, 1); rd(8'h40, 1); rd(8'h80, 1);
    // R3 parameters read back
    rd(8'h60, 3); rd(8'h70, 3);
    // R10 keys ignored while disabled
    wr(8'h10, 32'h1234, 10); wr(8'h20, 32'h99, 10); rd(8'h30, 10);
    // R2 enable and counting
    wr(8'h00, 32'h8000, 2); rd(8'h40, 2); rd(8'h40, 2); idle(3, 2); rd(8'h40, 2);
    // R3 window edge
    while (m_cnt < T - W - 1) idle(1, 3);
    rd(8'h30, 3); rd(8'h30, 3);
    // R4 valid service
    wr(8'h10, 32'h4000, 4); wr(8'h20, 32'h8, 4); rd(8'h40, 4); rd(8'h30, 4);
    // R7 unattended run-out
    while (m_cnt != T) idle(1, 7);
    idle(1, 7); rd(8'h30, 7); rd(8'h80, 7); rd(8'h40, 7);
    // R8 cause clear
    wr(8'h84, 32'hDF, 8); rd(8'h80, 8); wr(8'h84, 32'h20, 8); rd(8'h80, 8);
    // R6 release while window closed, release with no arming, wrong value
    wr(8'h10, 32'h4000, 6); wr(8'h20, 32'h8, 6); rd(8'h30, 6);
    while (m_cnt < T - W + 2) idle(1, 6);
    wr(8'h20, 32'h8, 6); wr(8'h10, 32'h4000, 6); wr(8'h20, 32'h9, 6); rd(8'h40, 6);
    // R5 wrong arming value
    wr(8'h10, 32'h1234, 5); rd(8'h30, 5);
    // R9 lockout after disable
    wr(8'h00, 32'h0, 9); rd(8'h00, 9); rd(8'h00, 9); rd(8'h40, 9);
    wr(8'h00, 32'h8000, 9); wr(8'h00, 32'h0, 9); wr(8'h00, 32'h8000, 9); rd(8'h00, 9);
    // R10 flags persist, then clear on reset
    idle(5, 10); rd(8'h30, 10);
    idle(2, 10);
    apply_reset();
    rd(8'h30, 10); rd(8'h80, 1);
    idle(3, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule